// File: doc/BRIEF.md
# Strobe-Driven FIFO with Read Rewind

This block is a single-device first-in first-out store of 9-bit words with a depth set by a parameter (256 by default, a power of two). It is driven by three active-low request lines: a write strobe, a read strobe and a rewind request. All three are brought into the system clock domain through two-flop synchronisers. Each strobe pulse is turned into at most one operation, on its synchronised falling edge.

Three active-low occupancy flags report the state of the store: empty, full and more-than-half. A write is refused while the store is full, and a read is refused while it is empty. A pulse on the rewind input moves the read side back to the first location, so the same data can be sent again. The write side is left where it is. The read data is qualified by an output-enable signal that stands for the high-impedance state of the output pins. The data outputs read as zero whenever that enable is low.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both pointers go to location 0. After such an edge `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `dout_oe` is 0.
- R2: A falling edge on `wr_n` stores `din` and a falling edge on `rd_n` presents the oldest stored word on `dout`, in write order. Each takes effect on the third rising clock edge after the strobe is first sampled low.
- R3: A write strobe that falls while `full_n` is 0 changes neither the write pointer nor the stored data.
- R4: A read strobe that falls while `empty_n` is 0 leaves the read pointer unchanged and does not raise `dout_oe`. The read that removes the last word is still carried out.
- R5: `empty_n` is 0 exactly when the store holds no words, and `empty_n` and `full_n` are never both 0.
- R6: `full_n` is 0 exactly when the store holds DEPTH words. With no reads after reset, it goes low on write number DEPTH and not before.
- R7: `half_n` goes to 0 on a committed write that leaves more than DEPTH/2 words. It returns to 1 on a rising edge of `rd_n` at which at most DEPTH/2 words remain.
- R8: A falling edge on `rtx_n` sets the read pointer to location 0 and leaves the write pointer unchanged. This happens only if both `wr_n` and `rd_n` are high (after synchronisation) at that moment.
- R9: `dout_oe` rises with an accepted read and falls on the following rising edge of `rd_n`. While `dout_oe` is 0, `dout` is all zeros.
- R10: After a rewind, `empty_n`, `full_n` and `half_n` are recomputed from the new difference between the pointers.
- R11: A read and a write committed on the same edge leave the occupancy unchanged, and the read returns the oldest word.
- R12: Holding a strobe low for many cycles produces one operation only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| rtx_n | input | 1 | Rewind request, active low, asynchronous |
| din | input | DATA_W (9) | Write data, held stable while `wr_n` is low |
| dout | output | DATA_W (9) | Read data, zero while `dout_oe` is low |
| dout_oe | output | 1 | Read data is being driven |
| full_n | output | 1 | Store holds DEPTH words, active low |
| empty_n | output | 1 | Store holds no words, active low |
| half_n | output | 1 | Store is more than half full, active low |

## Verification
On every cycle, the bound checker enforces the following:
- the flags agree with the pointer difference, and empty and full never appear together;
- a full store keeps its write pointer still, and an empty store keeps its read pointer still unless a rewind occurs;
- the half-full flag changes only on the correct side of DEPTH/2;
- a rewind zeroes the read pointer and keeps the write pointer;
- the data outputs stay quiet while the enable is low.

Some behaviours can only be shown by the directed scenarios:
- the data order;
- that an ignored strobe really loses its word;
- the exact write count at which full and half-full change;
- that a rewind is refused while a strobe is low;
- that a long strobe gives a single operation;
- that a combined read and write returns the oldest word.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  // Number of flops between an asynchronous strobe and its clean level.
  localparam int unsigned SYNC_STAGES = 2;

  // Occupancy relation used by the flag logic.
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_LOW   = 2'd1,
    OCC_HIGH  = 2'd2,
    OCC_FULL  = 2'd3
  } occ_zone_t;

  function automatic occ_zone_t classify_occ(
    input int unsigned occ,
    input int unsigned depth
  );
    if (occ == 0)              return OCC_EMPTY;
    else if (occ == depth)     return OCC_FULL;
    else if (occ > depth / 2)  return OCC_HIGH;
    else                       return OCC_LOW;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
// Brings an asynchronous active-low strobe into the clock domain and
// provides the current and previous clean levels for edge detection.
module strobe_sync #(
  parameter int unsigned STAGES = strobe_fifo_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic lvl,
  output logic prev
);
  localparam int unsigned TAPS = STAGES + 1;

  logic [TAPS-1:0] taps;

  generate
    genvar g;
    for (g = 0; g < TAPS; g++) begin : g_tap
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) taps[g] <= 1'b1;
          else        taps[g] <= strobe_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) taps[g] <= 1'b1;
          else        taps[g] <= taps[g-1];
        end
      end
    end
  endgenerate

  assign lvl  = taps[STAGES-1];
  assign prev = taps[STAGES];
endmodule

// File: rtl/fifo_store.sv
// Simple dual-port storage with a registered read port.
module fifo_store #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_ctrl.sv
// Pointer, flag and output-enable control.
module fifo_ctrl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fell,
  input  logic          rd_fell,
  input  logic          rd_rose,
  input  logic          rtx_go,
  output logic          wr_do,
  output logic          rd_do,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_n,
  output logic          oe
);
  import strobe_fifo_pkg::*;

  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] wr_ptr_nx;
  logic [PW-1:0] rd_ptr_nx;
  logic [PW-1:0] occ_nx;
  occ_zone_t     zone_nx;
  logic          half_nx;

  assign wr_do = wr_fell & full_n;
  assign rd_do = rd_fell & empty_n;

  always_comb begin
    wr_ptr_nx = wr_do ? wr_ptr + ONE : wr_ptr;
    if (rtx_go)     rd_ptr_nx = '0;
    else if (rd_do) rd_ptr_nx = rd_ptr + ONE;
    else            rd_ptr_nx = rd_ptr;
    occ_nx  = wr_ptr_nx - rd_ptr_nx;
    zone_nx = classify_occ(int'(occ_nx), DEPTH);
  end

  // Half-full is active high internally here; inverted at the register.
  always_comb begin
    half_nx = !half_n;
    if (rtx_go)
      half_nx = (zone_nx == OCC_HIGH) || (zone_nx == OCC_FULL);
    else if (wr_do && ((zone_nx == OCC_HIGH) || (zone_nx == OCC_FULL)))
      half_nx = 1'b1;
    else if (rd_rose && ((zone_nx == OCC_LOW) || (zone_nx == OCC_EMPTY)))
      half_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      full_n  <= 1'b1;
      empty_n <= 1'b0;
      half_n  <= 1'b1;
      oe      <= 1'b0;
    end else begin
      wr_ptr  <= wr_ptr_nx;
      rd_ptr  <= rd_ptr_nx;
      full_n  <= (zone_nx != OCC_FULL);
      empty_n <= (zone_nx != OCC_EMPTY);
      half_n  <= !half_nx;
      if (rd_do)        oe <= 1'b1;
      else if (rd_rose) oe <= 1'b0;
    end
  end
endmodule

// File: rtl/strobe_fifo.sv
// Top level: synchronised strobes, control, storage and gated output.
module strobe_fifo #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rtx_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              full_n,
  output logic              empty_n,
  output logic              half_n
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic wr_lvl, wr_prev, rd_lvl, rd_prev, rtx_lvl, rtx_prev;
  logic wr_fell, rd_fell, rd_rose, rtx_go;
  logic wr_do, rd_do;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [DATA_W-1:0] rdata;

  strobe_sync i_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .lvl(wr_lvl), .prev(wr_prev)
  );
  strobe_sync i_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .lvl(rd_lvl), .prev(rd_prev)
  );
  strobe_sync i_rtx_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(rtx_n), .lvl(rtx_lvl), .prev(rtx_prev)
  );

  assign wr_fell = wr_prev & ~wr_lvl;
  assign rd_fell = rd_prev & ~rd_lvl;
  assign rd_rose = ~rd_prev & rd_lvl;
  // Rewind is honoured only while both strobes rest high.
  assign rtx_go  = rtx_prev & ~rtx_lvl & wr_lvl & rd_lvl;

  fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_fell(wr_fell), .rd_fell(rd_fell), .rd_rose(rd_rose), .rtx_go(rtx_go),
    .wr_do(wr_do), .rd_do(rd_do), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full_n(full_n), .empty_n(empty_n), .half_n(half_n), .oe(dout_oe)
  );

  fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk(clk),
    .we(wr_do), .waddr(wr_ptr[AW-1:0]), .wdata(din),
    .re(rd_do), .raddr(rd_ptr[AW-1:0]), .rdata(rdata)
  );

  assign dout = dout_oe ? rdata : '0;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned PW    = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              full_n,
  input logic              empty_n,
  input logic              half_n,
  input logic              dout_oe,
  input logic [DATA_W-1:0] dout,
  input logic [PW-1:0]     wr_ptr,
  input logic [PW-1:0]     rd_ptr,
  input logic              rtx_go
);
  localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [PW-1:0] occ;
  assign occ = wr_ptr - rd_ptr;

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n && !empty_n));
  p_empty_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n) == (occ == '0));
  p_full_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n) == (occ == FULL));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |=> $stable(wr_ptr));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !rtx_go) |=> $stable(rd_ptr));
  p_half_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(half_n) |-> (occ > HALF));
  p_half_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_n) |-> (occ <= HALF));
  p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rtx_go |=> (rd_ptr == '0) && $stable(wr_ptr));
  p_quiet_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));
endmodule

bind strobe_fifo strobe_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .full_n(full_n), .empty_n(empty_n),
  .half_n(half_n), .dout_oe(dout_oe), .dout(dout),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rtx_go(rtx_go)
);

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 9;
  localparam int DEPTH  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, rtx_n = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic dout_oe, full_n, empty_n, half_n;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_strobe_fifo (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int i);
    return DATA_W'((i * 37 + 5) % 512);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rtx_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_word(input logic [DATA_W-1:0] d);
    @(negedge clk);
    din = d; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd_word(output logic [DATA_W-1:0] q, output logic oe_seen);
    @(negedge clk);
    rd_n = 1'b0;
    repeat (5) @(negedge clk);
    q = dout; oe_seen = dout_oe;
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic rtx_pulse();
    @(negedge clk);
    rtx_n = 1'b0;
    repeat (5) @(negedge clk);
    rtx_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 empty_n", 32'(empty_n), 0);
    chk("R1 full_n", 32'(full_n), 1);
    chk("R1 half_n", 32'(half_n), 1);
    chk("R1 dout_oe", 32'(dout_oe), 0);
    chk("R9 dout quiet", 32'(dout), 0);
  endtask

  task automatic t_basic();
    logic [DATA_W-1:0] q; logic oe;
    do_reset();
    wr_word(9'h0A5);
    chk("R5 empty_n after write", 32'(empty_n), 1);
    wr_word(9'h15A); wr_word(9'h1FF);
    rd_word(q, oe);
    chk("R2 first word", 32'(q), 32'h0A5);
    chk("R9 oe during read", 32'(oe), 1);
    chk("R9 oe after rise", 32'(dout_oe), 0);
    rd_word(q, oe);
    chk("R2 second word", 32'(q), 32'h15A);
    rd_word(q, oe);
    chk("R4 final read allowed", 32'(q), 32'h1FF);
    chk("R5 empty after last read", 32'(empty_n), 0);
  endtask

  task automatic t_empty_read();
    logic [DATA_W-1:0] q; logic oe;
    do_reset();
    rd_word(q, oe);
    chk("R4 no oe on empty read", 32'(oe), 0);
    wr_word(9'h033);
    rd_word(q, oe);
    chk("R4 read pointer unmoved", 32'(q), 32'h033);
    chk("R4 empty again", 32'(empty_n), 0);
  endtask

  task automatic t_hold();
    logic [DATA_W-1:0] q; logic oe;
    do_reset();
    @(negedge clk);
    din = 9'h111; wr_n = 1'b0;
    repeat (30) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_word(q, oe);
    chk("R12 held write gives one word", 32'(q), 32'h111);
    chk("R12 nothing left", 32'(empty_n), 0);
  endtask

  task automatic t_fill();
    logic [DATA_W-1:0] q; logic oe;
    int bad = 0;
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      wr_word(pat(i));
      if (i == DEPTH/2 - 1) chk("R7 half clear at DEPTH/2", 32'(half_n), 1);
      if (i == DEPTH/2)     chk("R7 half set above DEPTH/2", 32'(half_n), 0);
      if (i == DEPTH - 2)   chk("R6 not full at DEPTH-1", 32'(full_n), 1);
    end
    chk("R6 full at DEPTH", 32'(full_n), 0);
    chk("R5 not empty when full", 32'(empty_n), 1);
    wr_word(9'h1EE);
    chk("R3 still full", 32'(full_n), 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_word(q, oe);
      if (q !== pat(i)) bad++;
      if (i == DEPTH/2 - 2) chk("R7 half held above DEPTH/2", 32'(half_n), 0);
      if (i == DEPTH/2 - 1) chk("R7 half cleared on read rise", 32'(half_n), 1);
    end
    chk("R3 order intact, extra word dropped", 32'(bad), 0);
    chk("R5 empty after draining", 32'(empty_n), 0);
    rd_word(q, oe);
    chk("R4 read on empty refused", 32'(oe), 0);
  endtask

  task automatic t_rewind();
    logic [DATA_W-1:0] q; logic oe;
    int bad = 0;
    do_reset();
    for (int i = 0; i < 5; i++) wr_word(pat(100 + i));
    rd_word(q, oe); rd_word(q, oe);
    rtx_pulse();
    for (int i = 0; i < 5; i++) begin
      rd_word(q, oe);
      if (q !== pat(100 + i)) bad++;
    end
    chk("R8 rewind replays from first", 32'(bad), 0);
    chk("R5 empty after replay", 32'(empty_n), 0);
    rtx_pulse();
    chk("R10 empty flag recomputed", 32'(empty_n), 1);
    // rewind while read strobe low is refused
    @(negedge clk);
    rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 read of word 0", 32'(dout), 32'(pat(100)));
    rtx_n = 1'b0;
    repeat (5) @(negedge clk);
    rtx_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_word(q, oe);
    chk("R8 rewind refused with strobe low", 32'(q), 32'(pat(101)));
    rd_word(q, oe); rd_word(q, oe); rd_word(q, oe);
    wr_word(9'h0C3);
    rd_word(q, oe);
    chk("R8 write pointer kept", 32'(q), 32'h0C3);
  endtask

  task automatic t_rewind_flags();
    logic [DATA_W-1:0] q; logic oe;
    do_reset();
    for (int i = 0; i < 200; i++) wr_word(pat(i));
    for (int i = 0; i < 150; i++) rd_word(q, oe);
    chk("R7 half clear at 50 words", 32'(half_n), 1);
    rtx_pulse();
    chk("R10 half recomputed after rewind", 32'(half_n), 0);
    chk("R10 full stays clear", 32'(full_n), 1);
    rd_word(q, oe);
    chk("R8 rewound data", 32'(q), 32'(pat(0)));
  endtask

  task automatic t_simul();
    logic [DATA_W-1:0] q; logic oe;
    do_reset();
    wr_word(9'h001); wr_word(9'h002);
    @(negedge clk);
    din = 9'h003; wr_n = 1'b0; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 combined read returns oldest", 32'(dout), 32'h001);
    wr_n = 1'b1; rd_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_word(q, oe);
    chk("R11 second word", 32'(q), 32'h002);
    rd_word(q, oe);
    chk("R11 written word", 32'(q), 32'h003);
    chk("R11 occupancy held", 32'(empty_n), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_empty_read();
    t_hold();
    t_fill();
    t_rewind();
    t_rewind_flags();
    t_simul();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule